// File: doc/BRIEF.md
# Serial Port Command Decoder with Line Break Control

This block takes byte writes to a serial port's command register and turns them into one-shot actions. Only three bits of the byte carry a command. The actions are:

- restart the mode-register pointer
- reset the receive side or the transmit side
- clear the latched error flags or the break-change flag
- begin or end a break on the transmit line

The block keeps the receive FIFO occupancy, the status flags and the transmit and receive enables. It also owns a small transmit path: one holding register feeding a shift register that sends a start bit, eight data bits (least significant first) and a stop bit, advancing on a bit-time tick input.

A break can be requested while a character is shifting. In that case the line goes low only after that character's stop bit has finished. A character still waiting in the holding register goes out after the break is released. Each reset command touches only the flags named for it, so firmware can reconfigure one side of the port without disturbing the other.

Top module: `uart_cmd_unit`

## Requirements
- R1: The command code is taken from bits 6:4 of the written byte (bit 6 is the code's most significant bit). Bits 7 and 3:0 have no effect, and code 000 does nothing. A command strobed in cycle N changes the outputs at the clock edge that ends cycle N+1, and not earlier.
- R2: `mrPtr` is 0 after reset, meaning the first mode register is the target. A pulse on `mrAccess` sets it to 1. Code 001 returns it to 0.
- R3: Code 010 clears `rxEnabled` and sets `rxCount` to 0, which clears `rxReady` and `fifoFull`. `errFlags`, `deltaBreak` and the transmit side keep their values.
- R4: While the receiver is enabled, `rxPush` increments `rxCount` up to RX_DEPTH and `rxPop` decrements it. `fifoFull` is high at RX_DEPTH. A push to a full FIFO sets overrun flag `errFlags[0]`. A push while the receiver is disabled is ignored.
- R5: Code 011 clears `txEnabled`, which drops `txReady` and `txEmpty`. The receive enable and receive flags are unchanged.
- R6: `errFlags` holds four latched flags: bit 3 received break, bit 2 framing, bit 1 parity, bit 0 overrun. Code 100 clears all four and leaves `deltaBreak` unchanged.
- R7: Code 101 clears `deltaBreak` only. `errFlags` is unchanged.
- R8: On each tick the transmit path sends one bit of a frame: start 0, eight data bits least significant first, stop 1. A held character is loaded only while `ctsN` is low and the transmitter is enabled.
- R9: Code 110 is accepted only while `txEnabled` is high, and it ignores `ctsN`. On an idle line, `txd` goes low at the next tick.
- R10: A break requested during a character starts at the tick that ends that character's stop bit. A character in the holding register is sent after the break.
- R11: Code 111 returns `txd` high at the next tick and holds at least one further tick of mark before a held character starts, so the line is high within two bit-times.
- R12: `txBreak` is high exactly while the break holds `txd` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWrEn | input | 1 | Command register write strobe |
| cmdWrData | input | 8 | Command byte; code in bits 6:4 |
| bitTick | input | 1 | One-cycle pulse per bit-time |
| txEnable | input | 1 | Pulse: enable transmitter |
| rxEnable | input | 1 | Pulse: enable receiver |
| txWrEn | input | 1 | Write to transmit holding register |
| txWrData | input | 8 | Character to transmit |
| ctsN | input | 1 | Clear-to-send, active low |
| rxPush | input | 1 | Received character enters FIFO |
| rxPop | input | 1 | Character read from FIFO |
| errSet | input | 4 | Error events, same bit order as errFlags |
| breakChg | input | 1 | Break state change detected |
| mrAccess | input | 1 | Mode register access pulse |
| txd | output | 1 | Serial transmit line |
| txBreak | output | 1 | Break holding the line low |
| txEnabled | output | 1 | Transmitter enabled |
| txReady | output | 1 | Holding register can accept a character |
| txEmpty | output | 1 | Transmit path completely idle |
| rxEnabled | output | 1 | Receiver enabled |
| rxReady | output | 1 | FIFO not empty |
| fifoFull | output | 1 | FIFO holds RX_DEPTH characters |
| rxCount | output | 3 | FIFO occupancy |
| errFlags | output | 4 | Latched error flags |
| deltaBreak | output | 1 | Break-change flag |
| mrPtr | output | 1 | Mode register pointer |

## Verification
A stale break request or a break flag out of step with the line would show on `txd` within one or two ticks, as a frame out of order or a low line with no break flag. The serial monitor catches this by decoding every frame, including break frames, against the expected order. A reset command that clears a flag it should leave alone is visible one cycle after the command acts. The bench therefore first sets every other flag, then reads all of them at that cycle. A command acting a cycle early is caught by also sampling the cycle before.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;

  localparam int CMD_LSB = 4;
  localparam int CMD_MSB = 6;

  typedef enum logic [2:0] {
    CMD_NOP      = 3'b000,
    CMD_MR_RST   = 3'b001,
    CMD_RX_RST   = 3'b010,
    CMD_TX_RST   = 3'b011,
    CMD_ERR_CLR  = 3'b100,
    CMD_BCHG_CLR = 3'b101,
    CMD_BRK_ON   = 3'b110,
    CMD_BRK_OFF  = 3'b111
  } cmdCode_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic brkOn;
    logic brkOff;
  } txStrobe_t;

endpackage

// File: rtl/uart_cmd_txpath.sv
module uart_cmd_txpath
  import uart_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic              wrEn,
  input  logic              wrAllow,
  input  logic [DATA_W-1:0] wrData,
  output logic              holdFull,
  output logic              busy,
  output logic              lastBit,
  output logic              txd
);

  localparam int FRAME_W = DATA_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-1:0] shiftReg;
  logic [CNT_W-1:0]   bitsLeft;

  assign lastBit = busy && (bitsLeft == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      shiftReg <= '0;
      bitsLeft <= '0;
      busy     <= 1'b0;
      txd      <= 1'b1;
    end else begin
      if (strobe.load) begin
        shiftReg <= {1'b1, holdReg};
        bitsLeft <= CNT_W'(FRAME_W);
        busy     <= 1'b1;
        holdFull <= 1'b0;
        txd      <= 1'b0;
      end else if (strobe.shift) begin
        if (bitsLeft == '0) begin
          busy <= 1'b0;
        end else begin
          txd      <= shiftReg[0];
          shiftReg <= shiftReg >> 1;
          bitsLeft <= bitsLeft - 1'b1;
        end
      end
      if (strobe.brkOn) begin
        txd  <= 1'b0;
        busy <= 1'b0;
      end
      if (strobe.brkOff) begin
        txd <= 1'b1;
      end
      if (wrEn && wrAllow && !holdFull) begin
        holdReg  <= wrData;
        holdFull <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_cmd_ctrl.sv
module uart_cmd_ctrl
  import uart_cmd_pkg::*;
#(
  parameter int RX_DEPTH = 4,
  parameter int ERR_W    = 4,
  localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrEn,
  input  logic [2:0]       cmdField,
  input  logic             bitTick,
  input  logic             txEnable,
  input  logic             rxEnable,
  input  logic             ctsN,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic [ERR_W-1:0] errSet,
  input  logic             breakChg,
  input  logic             mrAccess,
  input  logic             holdFull,
  input  logic             busy,
  input  logic             lastBit,
  output txStrobe_t        strobe,
  output logic             txEnabled,
  output logic             rxEnabled,
  output logic [CNT_W-1:0] rxCount,
  output logic [ERR_W-1:0] errFlags,
  output logic             deltaBreak,
  output logic             mrPtr,
  output logic             breakActive,
  output logic             breakPend
);

  logic     cmdValid;
  cmdCode_t cmdCode;
  logic     stopPend;
  logic     markGuard;
  logic     canStart;
  logic     doPush;
  logic     doPop;
  logic     overrun;

  // decoded one-shot actions, one cycle after the write
  logic actMr, actRx, actTx, actErr, actBchg, actBrkOn, actBrkOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdCode  <= CMD_NOP;
    end else begin
      cmdValid <= cmdWrEn;
      cmdCode  <= cmdCode_t'(cmdField);
    end
  end

  always_comb begin
    actMr     = cmdValid && (cmdCode == CMD_MR_RST);
    actRx     = cmdValid && (cmdCode == CMD_RX_RST);
    actTx     = cmdValid && (cmdCode == CMD_TX_RST);
    actErr    = cmdValid && (cmdCode == CMD_ERR_CLR);
    actBchg   = cmdValid && (cmdCode == CMD_BCHG_CLR);
    actBrkOn  = cmdValid && (cmdCode == CMD_BRK_ON);
    actBrkOff = cmdValid && (cmdCode == CMD_BRK_OFF);
  end

  // transmit sequencing on bit ticks
  assign canStart = !busy || lastBit;

  always_comb begin
    strobe = '0;
    if (bitTick) begin
      if (breakPend && canStart) begin
        strobe.brkOn = 1'b1;
      end else if (breakActive && stopPend) begin
        strobe.brkOff = 1'b1;
      end else if (markGuard) begin
        strobe = '0;
      end else if (canStart && holdFull && txEnabled && !ctsN &&
                   !breakActive && !breakPend) begin
        strobe.load = 1'b1;
      end else if (busy) begin
        strobe.shift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      breakPend   <= 1'b0;
      breakActive <= 1'b0;
      stopPend    <= 1'b0;
      markGuard   <= 1'b0;
    end else begin
      if (strobe.brkOn) begin
        breakPend   <= 1'b0;
        breakActive <= 1'b1;
      end
      if (strobe.brkOff) begin
        breakActive <= 1'b0;
        stopPend    <= 1'b0;
        markGuard   <= 1'b1;
      end else if (bitTick && markGuard) begin
        markGuard <= 1'b0;
      end
      if (actBrkOn && txEnabled && !breakActive) begin
        breakPend <= 1'b1;
      end
      if (actBrkOff) begin
        if (breakPend && !strobe.brkOn) begin
          breakPend <= 1'b0;
        end else if (breakActive || strobe.brkOn) begin
          stopPend <= 1'b1;
        end
      end
    end
  end

  // enables, pointer and flags
  assign doPush  = rxPush && rxEnabled && (rxCount != CNT_W'(RX_DEPTH));
  assign doPop   = rxPop && (rxCount != '0);
  assign overrun = rxPush && rxEnabled && (rxCount == CNT_W'(RX_DEPTH)) && !rxPop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEnabled  <= 1'b0;
      rxEnabled  <= 1'b0;
      rxCount    <= '0;
      errFlags   <= '0;
      deltaBreak <= 1'b0;
      mrPtr      <= 1'b0;
    end else begin
      if (actTx)         txEnabled <= 1'b0;
      else if (txEnable) txEnabled <= 1'b1;

      if (actRx) begin
        rxEnabled <= 1'b0;
        rxCount   <= '0;
      end else begin
        if (rxEnable) rxEnabled <= 1'b1;
        if (doPush && !doPop)      rxCount <= rxCount + 1'b1;
        else if (doPop && !doPush) rxCount <= rxCount - 1'b1;
      end

      if (actErr) errFlags <= '0;
      else        errFlags <= errFlags | errSet | {{(ERR_W-1){1'b0}}, overrun};

      if (actBchg)       deltaBreak <= 1'b0;
      else if (breakChg) deltaBreak <= 1'b1;

      if (actMr)         mrPtr <= 1'b0;
      else if (mrAccess) mrPtr <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_cmd_unit.sv
module uart_cmd_unit
  import uart_cmd_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RX_DEPTH = 4,
  parameter int ERR_W    = 4,
  localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [7:0]        cmdWrData,
  input  logic              bitTick,
  input  logic              txEnable,
  input  logic              rxEnable,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              ctsN,
  input  logic              rxPush,
  input  logic              rxPop,
  input  logic [ERR_W-1:0]  errSet,
  input  logic              breakChg,
  input  logic              mrAccess,
  output logic              txd,
  output logic              txBreak,
  output logic              txEnabled,
  output logic              txReady,
  output logic              txEmpty,
  output logic              rxEnabled,
  output logic              rxReady,
  output logic              fifoFull,
  output logic [CNT_W-1:0]  rxCount,
  output logic [ERR_W-1:0]  errFlags,
  output logic              deltaBreak,
  output logic              mrPtr
);

  txStrobe_t strobe;
  logic      holdFull;
  logic      busy;
  logic      lastBit;
  logic      breakActive;
  logic      breakPend;

  uart_cmd_ctrl #(.RX_DEPTH(RX_DEPTH), .ERR_W(ERR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn),
    .cmdField(cmdWrData[CMD_MSB:CMD_LSB]), .bitTick(bitTick),
    .txEnable(txEnable), .rxEnable(rxEnable), .ctsN(ctsN),
    .rxPush(rxPush), .rxPop(rxPop), .errSet(errSet), .breakChg(breakChg),
    .mrAccess(mrAccess), .holdFull(holdFull), .busy(busy), .lastBit(lastBit),
    .strobe(strobe), .txEnabled(txEnabled), .rxEnabled(rxEnabled),
    .rxCount(rxCount), .errFlags(errFlags), .deltaBreak(deltaBreak),
    .mrPtr(mrPtr), .breakActive(breakActive), .breakPend(breakPend)
  );

  uart_cmd_txpath #(.DATA_W(DATA_W)) u_txpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(txWrEn),
    .wrAllow(txEnabled), .wrData(txWrData), .holdFull(holdFull),
    .busy(busy), .lastBit(lastBit), .txd(txd)
  );

  assign txBreak  = breakActive;
  assign txReady  = txEnabled && !holdFull;
  assign txEmpty  = txEnabled && !holdFull && !busy && !breakActive && !breakPend;
  assign rxReady  = (rxCount != '0);
  assign fifoFull = (rxCount == CNT_W'(RX_DEPTH));

endmodule

// File: rtl/uart_cmd_unit_chk.sv
module uart_cmd_unit_chk #(
  parameter int RX_DEPTH = 4,
  parameter int ERR_W    = 4,
  localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdWrEn,
  input logic [7:0]       cmdWrData,
  input logic             txd,
  input logic             txBreak,
  input logic             txEnabled,
  input logic             txReady,
  input logic             rxEnabled,
  input logic             rxReady,
  input logic             fifoFull,
  input logic [CNT_W-1:0] rxCount,
  input logic [ERR_W-1:0] errFlags,
  input logic             mrPtr
);

  assert_break_low_R12: assert property (@(posedge clk) disable iff (!rstN)
    txBreak |-> !txd);

  assert_stop_mark_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txBreak) |-> txd);

  assert_full_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> rxReady);

  assert_ready_enabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txEnabled);

  assert_rx_reset_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && cmdWrData[6:4] == 3'b010) |=> ##1 (!rxEnabled && rxCount == '0));

  assert_tx_reset_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && cmdWrData[6:4] == 3'b011) |=> ##1 !txEnabled);

  assert_mr_reset_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && cmdWrData[6:4] == 3'b001) |=> ##1 !mrPtr);

  assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrEn && cmdWrData[6:4] == 3'b100) |=> ##1 (errFlags == '0));

endmodule

bind uart_cmd_unit uart_cmd_unit_chk #(.RX_DEPTH(RX_DEPTH), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
  .txd(txd), .txBreak(txBreak), .txEnabled(txEnabled), .txReady(txReady),
  .rxEnabled(rxEnabled), .rxReady(rxReady), .fifoFull(fifoFull),
  .rxCount(rxCount), .errFlags(errFlags), .mrPtr(mrPtr)
);

// File: tb/uart_cmd_unit_bench.sv
module uart_cmd_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam logic [8:0] BRK = 9'h100;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdWrEn = 1'b0;
  logic [7:0] cmdWrData = '0;
  logic       bitTick = 1'b0;
  logic       txEnable = 1'b0, rxEnable = 1'b0;
  logic       txWrEn = 1'b0;
  logic [7:0] txWrData = '0;
  logic       ctsN = 1'b0;
  logic       rxPush = 1'b0, rxPop = 1'b0;
  logic [3:0] errSet = '0;
  logic       breakChg = 1'b0, mrAccess = 1'b0;
  logic       txd, txBreak, txEnabled, txReady, txEmpty;
  logic       rxEnabled, rxReady, fifoFull, deltaBreak, mrPtr;
  logic [2:0] rxCount;
  logic [3:0] errFlags;

  int checks = 0;
  int errors = 0;

  uart_cmd_unit u_uart_cmd_unit (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // bit-time tick generator
  int   tickCnt = 0;
  logic tickLast = 1'b0;
  always @(posedge clk) begin
    tickLast <= bitTick;
    if (!rstN) begin
      tickCnt <= 0;
      bitTick <= 1'b0;
    end else begin
      tickCnt <= (tickCnt == TICK_DIV-1) ? 0 : tickCnt + 1;
      bitTick <= (tickCnt == TICK_DIV-1);
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard of serial frames: byte values or BRK
  logic [8:0] expQ[$];
  int         mState = 0;
  int         mBits = 0;
  logic [8:0] mFrame;

  task automatic scoreFrame(logic [8:0] got);
    logic [8:0] exp;
    checks++;
    if (expQ.size() == 0) begin
      errors++;
      $display("FAIL R8 unexpected frame actual %0h expected none", got);
    end else begin
      exp = expQ.pop_front();
      if (got != exp) begin
        errors++;
        $display("FAIL R10 frame order actual %0h expected %0h", got, exp);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rstN && tickLast) begin
      case (mState)
        0: if (txd == 1'b0) begin mState = 1; mBits = 0; mFrame = '0; end
        1: begin
          mFrame[mBits] = txd;
          mBits++;
          if (mBits == 9) begin
            if (mFrame[8]) begin
              scoreFrame({1'b0, mFrame[7:0]});
              mState = 0;
            end else if (mFrame == '0) begin
              scoreFrame(BRK);
              mState = 2;
            end else begin
              scoreFrame(9'h1FF);
              mState = 2;
            end
          end
        end
        default: if (txd == 1'b1) mState = 0;
      endcase
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    cyc(1);
    sig = 1'b0;
  endtask

  // returns one negedge after the strobe cycle (before the command acts)
  task automatic writeCmd(logic [7:0] val);
    cmdWrData = val;
    cmdWrEn = 1'b1;
    cyc(1);
    cmdWrEn = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] val);
    txWrData = val;
    txWrEn = 1'b1;
    cyc(1);
    txWrEn = 1'b0;
  endtask

  task automatic waitDrain(string req);
    int n;
    n = 0;
    while ((expQ.size() != 0 || mState != 0) && n < 600) begin
      cyc(1);
      n++;
    end
    check(req, "scoreboard drained", (expQ.size() == 0) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // reset state
    check("R12", "txd idle", txd, 1);
    check("R12", "txBreak reset", txBreak, 0);
    check("R5", "txEnabled reset", txEnabled, 0);
    check("R4", "rxCount reset", rxCount, 0);
    check("R6", "errFlags reset", errFlags, 0);
    check("R2", "mrPtr reset", mrPtr, 0);

    // R2 pointer
    pulse(mrAccess);
    check("R2", "mrPtr after access", mrPtr, 1);
    writeCmd(8'h10);
    check("R1", "mrPtr before act cycle", mrPtr, 1);
    cyc(1);
    check("R2", "mrPtr after cmd 001", mrPtr, 0);

    // R4 fifo and flags
    pulse(rxEnable);
    for (int i = 0; i < 4; i++) pulse(rxPush);
    check("R4", "rxCount full", rxCount, 4);
    check("R4", "fifoFull", fifoFull, 1);
    check("R4", "rxReady", rxReady, 1);
    pulse(rxPush);
    check("R4", "overrun flag", errFlags, 4'b0001);
    errSet = 4'b1110; cyc(1); errSet = '0;
    pulse(breakChg);
    check("R6", "errFlags set", errFlags, 4'hF);
    pulse(rxPop);
    check("R4", "rxCount after pop", rxCount, 3);
    pulse(rxPush);

    // R1 code 000 with reserved bits set does nothing
    writeCmd(8'h8F);
    cyc(2);
    check("R1", "nop rxEnabled", rxEnabled, 1);
    check("R1", "nop rxCount", rxCount, 4);
    check("R1", "nop errFlags", errFlags, 4'hF);
    check("R1", "nop deltaBreak", deltaBreak, 1);

    // R3 receiver reset
    writeCmd(8'h20);
    check("R1", "rx still enabled before act", rxEnabled, 1);
    cyc(1);
    check("R3", "rxEnabled cleared", rxEnabled, 0);
    check("R3", "rxReady cleared", rxReady, 0);
    check("R3", "fifoFull cleared", fifoFull, 0);
    check("R3", "errFlags kept", errFlags, 4'hF);
    check("R3", "deltaBreak kept", deltaBreak, 1);
    pulse(rxPush);
    check("R4", "push ignored when disabled", rxCount, 0);

    // R7 break-change clear
    writeCmd(8'h50); cyc(1);
    check("R7", "deltaBreak cleared", deltaBreak, 0);
    check("R7", "errFlags kept", errFlags, 4'hF);

    // R6 error clear
    pulse(breakChg);
    writeCmd(8'hC0); cyc(1);
    check("R6", "errFlags cleared", errFlags, 0);
    check("R6", "deltaBreak kept", deltaBreak, 1);

    // R9 break refused while transmitter disabled
    writeCmd(8'h60);
    cyc(4 * TICK_DIV);
    check("R9", "break ignored when disabled txd", txd, 1);
    check("R9", "break ignored when disabled txBreak", txBreak, 0);

    // R8 a single frame
    pulse(txEnable);
    check("R5", "txReady after enable", txReady, 1);
    check("R5", "txEmpty after enable", txEmpty, 1);
    expQ.push_back(9'h0A5);
    sendByte(8'hA5);
    waitDrain("R8");

    // R8 held by CTS, R9 idle break ignores CTS
    ctsN = 1'b1;
    sendByte(8'h3C);
    cyc(4 * TICK_DIV);
    check("R8", "cts holds txd", txd, 1);
    check("R8", "held char blocks txReady", txReady, 0);
    expQ.push_back(BRK);
    writeCmd(8'h60);
    n = 0;
    while (txd != 1'b0 && n < TICK_DIV + 3) begin cyc(1); n++; end
    check("R9", "idle break within one bit-time", txd, 0);
    check("R12", "txBreak during break", txBreak, 1);
    cyc(14 * TICK_DIV);
    writeCmd(8'h70);
    n = 0;
    while (txd != 1'b1 && n < 2 * TICK_DIV + 3) begin cyc(1); n++; end
    check("R11", "line high within two bit-times", txd, 1);
    check("R12", "txBreak released", txBreak, 0);
    expQ.push_back(9'h03C);
    ctsN = 1'b0;
    waitDrain("R11");

    // R10 break during a character; held char follows the break
    expQ.push_back(9'h081);
    expQ.push_back(BRK);
    expQ.push_back(9'h07E);
    sendByte(8'h81);
    n = 0;
    while (txReady != 1'b1 && n < 4 * TICK_DIV) begin cyc(1); n++; end
    sendByte(8'h7E);
    writeCmd(8'h60);
    cyc(2 * TICK_DIV);
    check("R10", "break deferred while shifting", txBreak, 0);
    cyc(22 * TICK_DIV);
    check("R10", "break active after char", txBreak, 1);
    writeCmd(8'hF0);
    waitDrain("R10");

    // R5 transmitter reset leaves receive side alone
    pulse(rxEnable);
    writeCmd(8'h30);
    check("R1", "tx still enabled before act", txEnabled, 1);
    cyc(1);
    check("R5", "txEnabled cleared", txEnabled, 0);
    check("R5", "txReady cleared", txReady, 0);
    check("R5", "txEmpty cleared", txEmpty, 0);
    check("R5", "rxEnabled kept", rxEnabled, 1);

    cyc(5);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule